// File: doc/BRIEF.md
# Timestamp and Timer Pulse Generator

This block turns a fast reference enable (nominally a 19.2 MHz crystal tick, presented as a one-cycle enable in the system clock domain) into two kinds of time information. The first is a set of coarse timestamps. A single 56-bit free-running count advances on every reference tick. Three timestamp outputs (data-path log, tag and translation) each show that count shifted right by a programmable amount. A shift of 14 gives a resolution of roughly 853 µs and a shift of 24 roughly 874 ms. The log timestamp can be switched to a legacy millisecond count supplied from outside.

The second kind is a set of timer strobes. A divider programmed with its ratio minus one derives a common tick from the reference. For example, 191 divides 19.2 MHz by 192, giving 100 kHz. Three pulse generators count common ticks and emit a strobe at the period selected by a 3-bit granularity code. With a 100 kHz common tick, a typical setup uses code 3 (100 µs) on generator 0 and code 4 (1 ms) on generators 1 and 2. The divider has its own enable bit. Software clears it, changes the ratio, then sets it again. While the enable is low, all divider and generator counters are held at zero.

Configuration uses a one-cycle write port with a 2-bit address and 32-bit data.

Top module: `tbase_timer`

## Requirements
- R1: The base count starts at zero, rises by exactly one on each clock edge where `ref_tick` is high, and is unchanged on every other edge. It is a 56-bit count that wraps modulo 2^56.
- R2: `tag_ts` and `nat_ts` each equal the low 32 bits of the base count shifted right by that output's 6-bit shift field. A shift larger than 55 gives zero. At address 1, the log shift is in bits [5:0], the tag shift in bits [13:8] and the translation shift in bits [21:16].
- R3: When address 1 bit 6 is 1, `log_ts` is the shifted base count using the log shift. When that bit is 0, `log_ts` equals the `legacy_ms` input.
- R4: Address 0 holds the ratio minus one in bits [15:0] and the enable in bit 31. With value V and the enable set, a common tick occurs on every (V+1)-th reference tick.
- R5: While the enable is clear, no pulse is produced, and the divider and generator counters return to zero. After the enable is written to 1, the first pulse of a generator appears after one full period.
- R6: At address 2, generator g takes its code from bits [4g+2:4g]. The codes 0 to 7 give periods of 1, 2, 5, 10, 100, 1000, 10000 and 65535 common ticks. A pulse is produced after that many ticks, and then again after every further such number of ticks.
- R7: A pulse is a strobe that rises one clock after the edge that carries the completing reference tick. With ticks spaced more than one clock apart, it lasts exactly one clock.
- R8: After reset, the enable is clear, all fields are zero, all pulses are low, and `log_ts` follows `legacy_ms`.
- R9: A write to address 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Reference crystal tick enable |
| legacy_ms | input | 32 | Legacy millisecond count for the log timestamp |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| log_ts | output | 32 | Data-path log timestamp |
| tag_ts | output | 32 | Tag timestamp |
| nat_ts | output | 32 | Address translation timestamp |
| pulse | output | 3 | Timer strobes, one per generator |

## Verification
A wrong base count shows on the very next clock at any timestamp whose shift is zero. With large shifts it shows only once the error reaches the selected bit. A divider or generator counter that is off by one, or that is not cleared when the enable drops, moves the next strobe by at least one clock, so the error appears at the first pulse after the fault. That can be as long as one full period. A stray strobe while the divider is disabled shows in the same cycle it occurs.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int BASE_W  = 56;
  localparam int TS_W    = 32;
  localparam int DIV_W   = 16;
  localparam int SHIFT_W = 6;
  localparam int GRAN_W  = 3;
  localparam int PER_W   = 16;

  typedef enum logic [1:0] {
    ADDR_DIV   = 2'd0,
    ADDR_STAMP = 2'd1,
    ADDR_GRAN  = 2'd2,
    ADDR_NONE  = 2'd3
  } cfg_addr_e;

  // period of a granularity code in common-tick units
  function automatic logic [PER_W-1:0] gran_period(input logic [GRAN_W-1:0] code);
    case (code)
      3'd0:    gran_period = 16'd1;
      3'd1:    gran_period = 16'd2;
      3'd2:    gran_period = 16'd5;
      3'd3:    gran_period = 16'd10;
      3'd4:    gran_period = 16'd100;
      3'd5:    gran_period = 16'd1000;
      3'd6:    gran_period = 16'd10000;
      default: gran_period = 16'd65535;
    endcase
  endfunction
endpackage

// File: rtl/tbase_regs.sv
module tbase_regs
  import tbase_pkg::*;
#(
  parameter int NGEN = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [1:0]               addr,
  input  logic [31:0]              wdata,
  output logic [DIV_W-1:0]         div_val,
  output logic                     div_on,
  output logic [SHIFT_W-1:0]       log_sh,
  output logic                     log_sel,
  output logic [SHIFT_W-1:0]       tag_sh,
  output logic [SHIFT_W-1:0]       nat_sh,
  output logic [NGEN*GRAN_W-1:0]   gran
);
  logic [DIV_W-1:0]       div_val_d;
  logic                   div_on_d, log_sel_d;
  logic [SHIFT_W-1:0]     log_sh_d, tag_sh_d, nat_sh_d;
  logic [NGEN*GRAN_W-1:0] gran_d;

  always_comb begin
    div_val_d = div_val;
    div_on_d  = div_on;
    log_sh_d  = log_sh;
    log_sel_d = log_sel;
    tag_sh_d  = tag_sh;
    nat_sh_d  = nat_sh;
    gran_d    = gran;
    if (we) begin
      case (cfg_addr_e'(addr))
        ADDR_DIV: begin
          div_val_d = wdata[DIV_W-1:0];
          div_on_d  = wdata[31];
        end
        ADDR_STAMP: begin
          log_sh_d  = wdata[SHIFT_W-1:0];
          log_sel_d = wdata[6];
          tag_sh_d  = wdata[8 +: SHIFT_W];
          nat_sh_d  = wdata[16 +: SHIFT_W];
        end
        ADDR_GRAN: begin
          for (int g = 0; g < NGEN; g++)
            gran_d[g*GRAN_W +: GRAN_W] = wdata[g*4 +: GRAN_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_val <= '0;
      div_on  <= 1'b0;
      log_sh  <= '0;
      log_sel <= 1'b0;
      tag_sh  <= '0;
      nat_sh  <= '0;
      gran    <= '0;
    end else begin
      div_val <= div_val_d;
      div_on  <= div_on_d;
      log_sh  <= log_sh_d;
      log_sel <= log_sel_d;
      tag_sh  <= tag_sh_d;
      nat_sh  <= nat_sh_d;
      gran    <= gran_d;
    end
  end
endmodule

// File: rtl/tbase_stamp.sv
module tbase_stamp
  import tbase_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic [SHIFT_W-1:0] log_sh,
  input  logic               log_sel,
  input  logic [SHIFT_W-1:0] tag_sh,
  input  logic [SHIFT_W-1:0] nat_sh,
  input  logic [TS_W-1:0]    legacy_ms,
  output logic [BASE_W-1:0]  base,
  output logic [TS_W-1:0]    log_ts,
  output logic [TS_W-1:0]    tag_ts,
  output logic [TS_W-1:0]    nat_ts
);
  logic [BASE_W-1:0] base_d;
  logic [BASE_W-1:0] log_win, tag_win, nat_win;

  always_comb begin
    base_d = base;
    if (ref_tick) base_d = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base <= '0;
    else        base <= base_d;
  end

  assign log_win = base >> log_sh;
  assign tag_win = base >> tag_sh;
  assign nat_win = base >> nat_sh;

  assign log_ts = log_sel ? log_win[TS_W-1:0] : legacy_ms;
  assign tag_ts = tag_win[TS_W-1:0];
  assign nat_ts = nat_win[TS_W-1:0];
endmodule

// File: rtl/tbase_divider.sv
module tbase_divider
  import tbase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             div_on,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, cnt_d;
  logic             at_end;

  assign at_end = (cnt >= div_val);

  always_comb begin
    tick  = div_on && ref_tick && at_end;
    cnt_d = cnt;
    if (!div_on)       cnt_d = '0;
    else if (ref_tick) cnt_d = at_end ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/tbase_pulse.sv
module tbase_pulse
  import tbase_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_on,
  input  logic              tick,
  input  logic [GRAN_W-1:0] code,
  output logic              strobe
);
  logic [PER_W-1:0] cnt, cnt_d, last;
  logic             wrap, strobe_d;

  assign last = gran_period(code) - 1'b1;
  assign wrap = (cnt >= last);

  always_comb begin
    cnt_d    = cnt;
    strobe_d = 1'b0;
    if (!div_on) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d    = wrap ? '0 : cnt + 1'b1;
      strobe_d = wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      strobe <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      strobe <= strobe_d;
    end
  end
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int NGEN = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic [31:0]     legacy_ms,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_addr,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     log_ts,
  output logic [31:0]     tag_ts,
  output logic [31:0]     nat_ts,
  output logic [NGEN-1:0] pulse
);
  logic [DIV_W-1:0]       div_val;
  logic                   div_on, log_sel, tick;
  logic [SHIFT_W-1:0]     log_sh, tag_sh, nat_sh;
  logic [NGEN*GRAN_W-1:0] gran;
  logic [BASE_W-1:0]      base_cnt;

  tbase_regs #(.NGEN(NGEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .div_val(div_val), .div_on(div_on), .log_sh(log_sh), .log_sel(log_sel),
    .tag_sh(tag_sh), .nat_sh(nat_sh), .gran(gran)
  );

  tbase_stamp u_stamp (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .log_sh(log_sh), .log_sel(log_sel), .tag_sh(tag_sh), .nat_sh(nat_sh),
    .legacy_ms(legacy_ms), .base(base_cnt),
    .log_ts(log_ts), .tag_ts(tag_ts), .nat_ts(nat_ts)
  );

  tbase_divider u_div (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .div_on(div_on), .div_val(div_val), .tick(tick)
  );

  for (genvar g = 0; g < NGEN; g++) begin : g_gen
    tbase_pulse u_pulse (
      .clk(clk), .rst_n(rst_n), .div_on(div_on), .tick(tick),
      .code(gran[g*GRAN_W +: GRAN_W]), .strobe(pulse[g])
    );
  end
endmodule

// File: rtl/tbase_timer_chk.sv
module tbase_timer_chk #(
  parameter int NGEN   = 3,
  parameter int BASE_W = 56
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_tick,
  input logic              cfg_we,
  input logic [1:0]        cfg_addr,
  input logic [BASE_W-1:0] base_cnt,
  input logic              div_on,
  input logic [NGEN-1:0]   pulse,
  input logic [31:0]       tag_ts,
  input logic [31:0]       nat_ts
);
  logic alive;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive <= 1'b0;
    else        alive <= 1'b1;
  end

  // R1
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alive && ref_tick |=> base_cnt == $past(base_cnt) + 1'b1);

  // R1
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alive && !ref_tick |=> $stable(base_cnt));

  // R5
  quiet_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alive && !div_on |=> pulse == '0);

  // R7
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alive && pulse != '0 |-> $past(ref_tick) && $past(div_on));

  // R9
  dead_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alive && cfg_we && cfg_addr == 2'd3 && !ref_tick |=> $stable(tag_ts) && $stable(nat_ts));
endmodule

bind tbase_timer tbase_timer_chk #(.NGEN(NGEN), .BASE_W(tbase_pkg::BASE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .base_cnt(base_cnt), .div_on(div_on), .pulse(pulse), .tag_ts(tag_ts), .nat_ts(nat_ts)
);

// File: tb/tbase_timer_test.sv
module tbase_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic [31:0] legacy_ms = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] log_ts, tag_ts, nat_ts;
  logic [2:0]  pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R6";

  // reference model state
  logic [55:0] m_base;
  logic [15:0] m_div, m_dcnt;
  logic        m_en, m_sel;
  logic [5:0]  m_lsh, m_tsh, m_nsh;
  logic [2:0]  m_gran [3];
  int          m_pc [3];
  logic [2:0]  m_pulse;

  tbase_timer uut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .legacy_ms(legacy_ms),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .log_ts(log_ts), .tag_ts(tag_ts), .nat_ts(nat_ts), .pulse(pulse)
  );

  always #5 clk = ~clk;

  function automatic int period_of(input logic [2:0] c);
    case (c)
      3'd0: return 1;     3'd1: return 2;    3'd2: return 5;     3'd3: return 10;
      3'd4: return 100;   3'd5: return 1000; 3'd6: return 10000; default: return 65535;
    endcase
  endfunction

  function automatic logic [31:0] win(input logic [55:0] b, input logic [5:0] s);
    logic [55:0] t;
    t = b >> s;
    return t[31:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_base = '0; m_div = '0; m_dcnt = '0; m_en = 0; m_sel = 0;
    m_lsh = '0; m_tsh = '0; m_nsh = '0; m_pulse = '0;
    for (int g = 0; g < 3; g++) begin m_gran[g] = '0; m_pc[g] = 0; end
  endtask

  task automatic model_step();
    bit tk;
    tk = m_en && ref_tick && (m_dcnt >= m_div);
    for (int g = 0; g < 3; g++) begin
      int p;
      p = period_of(m_gran[g]);
      m_pulse[g] = tk && (m_pc[g] >= p - 1);
      if (!m_en) m_pc[g] = 0;
      else if (tk) m_pc[g] = (m_pc[g] >= p - 1) ? 0 : m_pc[g] + 1;
    end
    if (!m_en) m_dcnt = '0;
    else if (ref_tick) m_dcnt = (m_dcnt >= m_div) ? '0 : m_dcnt + 1'b1;
    if (ref_tick) m_base = m_base + 1'b1;
    if (cfg_we) begin
      case (cfg_addr)
        2'd0: begin m_div = cfg_wdata[15:0]; m_en = cfg_wdata[31]; end
        2'd1: begin m_lsh = cfg_wdata[5:0]; m_sel = cfg_wdata[6];
                    m_tsh = cfg_wdata[13:8]; m_nsh = cfg_wdata[21:16]; end
        2'd2: for (int g = 0; g < 3; g++) m_gran[g] = cfg_wdata[g*4 +: 3];
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    logic [31:0] el;
    el = m_sel ? win(m_base, m_lsh) : legacy_ms;
    check(log_ts == el, m_sel ? "R2" : "R3", "log_ts", log_ts, el);
    check(tag_ts == win(m_base, m_tsh), "R2", "tag_ts", tag_ts, win(m_base, m_tsh));
    check(nat_ts == win(m_base, m_nsh), "R2", "nat_ts", nat_ts, win(m_base, m_nsh));
    check(pulse == m_pulse, cur_req, "pulse", pulse, m_pulse);
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    cyc();
    cfg_we = 0;
  endtask

  // cycles from now until pulse[g] is seen, limit lim
  task automatic wait_pulse(input int g, input int lim, output int n);
    n = 0;
    do begin
      cyc();
      n++;
    end while (!pulse[g] && n < lim);
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R8 reset state
    check(pulse == 3'b000, "R8", "pulse after reset", pulse, 0);
    check(tag_ts == 0 && nat_ts == 0, "R8", "stamps after reset", tag_ts, 0);
    legacy_ms = 32'h1234_5678;
    #1;
    check(log_ts == 32'h1234_5678, "R8", "log follows legacy", log_ts, 32'h1234_5678);

    // R5 / R8: divider off, ticks running, no pulses
    cur_req = "R5";
    ref_tick = 1;
    repeat (30) cyc();

    // R1: counting with shift 0
    cur_req = "R1";
    wr(2'd1, 32'h0000_0000);
    for (int i = 0; i < 40; i++) begin ref_tick = i[0]; cyc(); end
    check(tag_ts == m_base[31:0], "R1", "base count", tag_ts, m_base[31:0]);

    // R3: legacy select vs shifted
    cur_req = "R3";
    wr(2'd1, 32'h0002_0140);
    ref_tick = 1;
    repeat (5) cyc();
    wr(2'd1, 32'h0003_0203);
    for (int i = 0; i < 5; i++) begin legacy_ms = $urandom; cyc(); end

    // R4 / R6: divide by 4, generator codes 0,1,2
    cur_req = "R4";
    ref_tick = 1;
    wr(2'd2, 32'h0000_0210);
    wr(2'd0, 32'h8000_0003);
    wait_pulse(0, 100, n);
    check(n == 4, "R5", "first pulse gen0 after enable", n, 4);
    wait_pulse(0, 100, n);
    check(n == 4, "R4", "gen0 interval div 4", n, 4);
    cur_req = "R6";
    wait_pulse(2, 100, n);
    wait_pulse(2, 100, n);
    check(n == 20, "R6", "gen2 interval code 2", n, 20);

    // R5: disable mid-period, re-enable gives full period
    cur_req = "R5";
    wr(2'd2, 32'h0000_0333);
    wr(2'd0, 32'h8000_0001);
    repeat (7) cyc();
    wr(2'd0, 32'h0000_0001);
    repeat (10) cyc();
    check(pulse == 0, "R5", "no pulse while disabled", pulse, 0);
    wr(2'd0, 32'h8000_0001);
    wait_pulse(1, 100, n);
    check(n == 20, "R5", "full period after re-enable", n, 20);

    // R7: strobe width with ticks every other reference tick
    cur_req = "R7";
    wr(2'd2, 32'h0000_0000);
    wait_pulse(0, 10, n);
    check(pulse[0] == 1, "R7", "strobe high", pulse[0], 1);
    cyc();
    check(pulse[0] == 0, "R7", "strobe one cycle", pulse[0], 0);

    // R9: write to unused address
    cur_req = "R9";
    ref_tick = 0;
    wr(2'd1, 32'h0000_0100);
    wr(2'd3, 32'hFFFF_FFFF);
    cyc();
    check(tag_ts == win(m_base, 6'd1), "R9", "tag shift kept", tag_ts, win(m_base, 6'd1));
    wr(2'd2, 32'h0000_0000);
    wr(2'd0, 32'h8000_0000);
    wr(2'd3, 32'h0000_0000);
    ref_tick = 1;
    cyc(); cyc();
    check(pulse[0] == 1, "R9", "divider still on", pulse[0], 1);

    // R2: shift past the count width
    cur_req = "R2";
    wr(2'd1, 32'h003F_3800);
    check(tag_ts == 0, "R2", "shift 56 gives zero", tag_ts, 0);

    // random mix, divider changed under the disable protocol
    cur_req = "R6";
    for (int k = 0; k < 60; k++) begin
      wr(2'd0, {1'b0, 15'd0, 16'($urandom_range(0, 5))} | (m_div & 32'h0));
      wr(2'd2, $urandom & 32'h0000_0333);
      wr(2'd1, $urandom);
      wr(2'd0, 32'h8000_0000 | 32'(m_div));
      for (int i = 0; i < 50; i++) begin
        ref_tick = ($urandom_range(0, 3) != 0);
        legacy_ms = $urandom;
        cyc();
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule